// File: doc/BRIEF.md
# Gated Pixel Clock Frequency Counter

This block estimates the rate of an unknown pixel clock by counting its rising edges during a window timed by a reference oscillator clock. The host writes an interval value N through a plain register strobe. That write sets the window length to N reference clock periods and starts a measurement at once. The pixel domain counts edges while the window is open. Once the pixel-side counter has stopped, the count is handed back to the reference domain, where the read data port presents it. Turning the count into a frequency is left to software.

The window opening is carried into the pixel domain by a multi-flop synchronizer. The pixel side echoes the level it has seen back to the reference domain. When the count is final, the pixel side flips a completion toggle, which the reference side picks up through its own synchronizer before it takes the stable count. The write strobe has no valid/ready pair. It is always accepted and cannot be back-pressured: a write during a run aborts that run and replaces it. `busy` reports that a measurement is pending or running.

Top module: `pix_freq_meter`

## Requirements
- R1: Writing a nonzero interval N starts a measurement. `busy` is 1 from the cycle after the write strobe until the new result is on `rd_data`.
- R2: For a window long enough for the pixel side to acknowledge its start, the published result is within one of N × Tref / Tpix, the number of pixel clock rising edges in N reference periods.
- R3: The count crosses back to the reference domain only after the pixel-side counter has stopped. While the pixel side sees the window closed, its count does not change, and its held result changes only together with the completion toggle.
- R4: The edge count saturates at its all-ones value (0xFF for 8 bits) and does not wrap.
- R5: After reset, `rd_data` is 0x00 and `busy` is 0.
- R6: Writing an interval of 0 opens no window. The result becomes 0 and `busy` falls one cycle after it rose.
- R7: A write during a running measurement aborts it. The aborted count is never published, and the result of the new interval is.
- R8: While a measurement runs, `rd_data` keeps showing the result of the last completed measurement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference oscillator clock; times the window |
| ref_rst_n | input | 1 | Active-low asynchronous reset, reference domain |
| pix_clk | input | 1 | Pixel clock under measurement |
| pix_rst_n | input | 1 | Active-low asynchronous reset, pixel domain |
| wr_en | input | 1 | Register write strobe; starts (or restarts) a measurement |
| wr_data | input | INT_W (8) | Window length in reference clock periods |
| rd_data | output | CNT_W (8) | Edge count of the last completed measurement |
| busy | output | 1 | A measurement is pending or running |

## Verification
The bench builds the block with its default parameters: an 8-bit interval, an 8-bit count and two synchronizer stages. It runs the pixel clock at twice the reference rate, with a sub-cycle phase offset, and at 0.4 times the reference rate. With an 8-bit count, a 200-period window at twice the rate overruns 0xFF, so saturation can be reached. Short windows, an empty window, an abort in mid-window and a read taken during a run cover the handshake and publication corners.

// File: rtl/pfm_pkg.sv
`timescale 1ns/1ps
package pfm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_OPEN  = 2'd1,
    ST_CLOSE = 2'd2
  } meas_state_t;
endpackage

// File: rtl/pfm_sync.sv
`timescale 1ns/1ps
module pfm_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pfm_pix_counter.sv
`timescale 1ns/1ps
module pfm_pix_counter #(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  output logic             run_s,
  output logic             done_tgl,
  output logic [CNT_W-1:0] hold_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             run_q;
  logic [CNT_W-1:0] cnt;

  pfm_sync #(.W(1), .STAGES(SYNC_STAGES)) u_req_sync (
    .clk(clk), .rst_n(rst_n), .d(req), .q(run_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      cnt      <= '0;
      hold_cnt <= '0;
      done_tgl <= 1'b0;
    end else begin
      run_q <= run_s;
      if (run_s && !run_q) begin
        cnt <= CNT_W'(1);
      end else if (run_s) begin
        if (cnt != CNT_MAX) cnt <= cnt + CNT_W'(1);
      end else if (run_q) begin
        hold_cnt <= cnt;
        done_tgl <= ~done_tgl;
      end
    end
  end

  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX && run_s && run_q) |=> cnt == CNT_MAX); // R4
  AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> $stable(cnt)); // R3
  AST_HOLD_WITH_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(hold_cnt) |-> !$stable(done_tgl)); // R3
endmodule

// File: rtl/pfm_ref_ctrl.sv
`timescale 1ns/1ps
module pfm_ref_ctrl
  import pfm_pkg::*;
#(
  parameter int INT_W       = 8,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [INT_W-1:0] wr_data,
  input  logic             run_pix,
  input  logic             done_tgl_pix,
  input  logic [CNT_W-1:0] hold_cnt,
  output logic             req,
  output logic [CNT_W-1:0] result,
  output logic             busy
);
  meas_state_t      state;
  logic             pend;
  logic [INT_W-1:0] pend_int;
  logic [INT_W-1:0] win_cnt;
  logic             seen;
  logic             got_done;
  logic             done_q;
  logic             ack_s;
  logic             done_s;
  logic             done_evt;
  logic             pend_clr;
  logic             stop_now;

  pfm_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .d(run_pix), .q(ack_s)
  );
  pfm_sync #(.W(1), .STAGES(SYNC_STAGES)) u_done_sync (
    .clk(clk), .rst_n(rst_n), .d(done_tgl_pix), .q(done_s)
  );

  assign done_evt = done_s ^ done_q;
  assign busy     = (state != ST_IDLE) || pend;

  always_comb begin
    pend_clr = (state == ST_IDLE) && pend;
    stop_now = ((win_cnt == INT_W'(1)) || pend) && (seen || ack_s);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      pend     <= 1'b0;
      pend_int <= '0;
      win_cnt  <= '0;
      seen     <= 1'b0;
      got_done <= 1'b0;
      done_q   <= 1'b0;
      req      <= 1'b0;
      result   <= '0;
    end else begin
      done_q <= done_s;
      if (wr_en) begin
        pend     <= 1'b1;
        pend_int <= wr_data;
      end else if (pend_clr) begin
        pend <= 1'b0;
      end
      unique case (state)
        ST_IDLE: begin
          if (pend) begin
            if (pend_int == '0) begin
              result <= '0;
            end else begin
              req     <= 1'b1;
              win_cnt <= pend_int;
              seen    <= 1'b0;
              state   <= ST_OPEN;
            end
          end
        end
        ST_OPEN: begin
          if (ack_s) seen <= 1'b1;
          if (win_cnt > INT_W'(1)) win_cnt <= win_cnt - INT_W'(1);
          if (stop_now) begin
            req      <= 1'b0;
            got_done <= 1'b0;
            state    <= ST_CLOSE;
          end
        end
        ST_CLOSE: begin
          if ((got_done || done_evt) && !ack_s) begin
            if (!pend) result <= hold_cnt;
            got_done <= 1'b0;
            state    <= ST_IDLE;
          end else if (done_evt) begin
            got_done <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_BUSY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> busy); // R1
  AST_RESULT_HELD_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OPEN) |=> $stable(result)); // R8
  AST_ZERO_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && pend && pend_int == '0) |=> (result == '0 && !req)); // R6
  AST_DROP_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req) |-> $past(seen || ack_s)); // R3
endmodule

// File: rtl/pix_freq_meter.sv
`timescale 1ns/1ps
module pix_freq_meter #(
  parameter int INT_W       = 8,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             ref_clk,
  input  logic             ref_rst_n,
  input  logic             pix_clk,
  input  logic             pix_rst_n,
  input  logic             wr_en,
  input  logic [INT_W-1:0] wr_data,
  output logic [CNT_W-1:0] rd_data,
  output logic             busy
);
  logic             req;
  logic             run_s;
  logic             done_tgl;
  logic [CNT_W-1:0] hold_cnt;

  pfm_ref_ctrl #(.INT_W(INT_W), .CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_ref (
    .clk(ref_clk), .rst_n(ref_rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .run_pix(run_s), .done_tgl_pix(done_tgl), .hold_cnt(hold_cnt),
    .req(req), .result(rd_data), .busy(busy)
  );

  pfm_pix_counter #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_pix (
    .clk(pix_clk), .rst_n(pix_rst_n), .req(req),
    .run_s(run_s), .done_tgl(done_tgl), .hold_cnt(hold_cnt)
  );
endmodule

// File: tb/pix_freq_meter_bench.sv
`timescale 1ns/1ps
module pix_freq_meter_bench;
  logic       ref_clk = 1'b0;
  logic       pix_clk = 1'b0;
  logic       ref_rst_n = 1'b0;
  logic       pix_rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       busy;
  real        pix_half = 1.0;
  int         total = 0;
  int         bad = 0;

  pix_freq_meter u_pix_freq_meter (
    .ref_clk(ref_clk), .ref_rst_n(ref_rst_n), .pix_clk(pix_clk), .pix_rst_n(pix_rst_n),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .busy(busy)
  );

  always #2 ref_clk = ~ref_clk;
  initial begin
    #0.5;
    forever #(pix_half) pix_clk = ~pix_clk;
  end

  task automatic check_range(string tag, int act, int lo, int hi);
    total++;
    if (act < lo || act > hi) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic do_write(logic [7:0] v);
    @(negedge ref_clk);
    wr_en = 1'b1;
    wr_data = v;
    @(negedge ref_clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4000; i++) begin
      if (!busy) break;
      @(negedge ref_clk);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge ref_clk);
    check_range("R5 rd_data after reset", int'(rd_data), 0, 0);
    check_range("R5 busy after reset", int'(busy), 0, 0);
    ref_rst_n = 1'b1;
    pix_rst_n = 1'b1;
    repeat (2) @(negedge ref_clk);
    check_range("R5 busy idle after release", int'(busy), 0, 0);
  endtask

  task automatic t_measure(int n, int exp_lo, int exp_hi, string tag);
    do_write(8'(n));
    check_range({tag, " R1 busy after write"}, int'(busy), 1, 1);
    wait_idle();
    check_range({tag, " R1 busy cleared"}, int'(busy), 0, 0);
    check_range(tag, int'(rd_data), exp_lo, exp_hi);
  endtask

  task automatic t_zero();
    do_write(8'd0);
    check_range("R6 busy one cycle after zero write", int'(busy), 1, 1);
    @(negedge ref_clk);
    check_range("R6 busy dropped", int'(busy), 0, 0);
    check_range("R6 zero window result", int'(rd_data), 0, 0);
  endtask

  task automatic t_read_during();
    int prev;
    prev = int'(rd_data);
    do_write(8'd100);
    repeat (30) @(negedge ref_clk);
    check_range("R8 busy during run", int'(busy), 1, 1);
    check_range("R8 rd_data keeps last result", int'(rd_data), prev, prev);
    wait_idle();
    check_range("R8 new result after run", int'(rd_data), 199, 201);
  endtask

  task automatic t_abort();
    do_write(8'd200);
    repeat (20) @(negedge ref_clk);
    do_write(8'd10);
    check_range("R7 busy across abort", int'(busy), 1, 1);
    wait_idle();
    check_range("R7 result of restarted window", int'(rd_data), 19, 21);
  endtask

  initial begin
    #400000;
    bad++;
    total++;
    $display("FAIL watchdog R1 actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_measure(10, 19, 21, "R2 fast clock N=10");
    t_measure(50, 99, 101, "R2 fast clock N=50");
    t_zero();
    t_measure(200, 255, 255, "R4 saturation N=200");
    t_measure(127, 253, 255, "R2 near full N=127");
    t_measure(10, 19, 21, "R3 clean restart after saturation");
    t_read_during();
    t_abort();
    wait_idle();
    pix_half = 5.0;
    repeat (10) @(negedge ref_clk);
    t_measure(100, 39, 41, "R2 slow clock N=100");
    t_measure(200, 79, 81, "R2 slow clock N=200");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule